// File: doc/BRIEF.md
# Core Timer with Periodic Tick Interrupt

This block is a free-running counter that advances on every clock and produces two kinds of timing event. A wrap event occurs whenever the low eight stages of the counter pass from all ones back to zero. A periodic tick event occurs whenever one chosen upper counter bit goes from 0 to 1. A two-bit rate field picks which of four consecutive bits is used. Each event latches a sticky flag. Each flag has its own enable, and the interrupt line is active while any enabled flag is set.

Software reaches the block through a single byte-wide register with a select, a write strobe and a combinational read path. The flags are read-only. Each flag has its own write-only clear bit, and writing 1 there clears that flag. The chosen tick pulse is also exported so that an external watchdog can count it. Changing the rate field therefore changes the watchdog period as well.

Top module: `core_tick_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, the register reads 0x03: both flags 0, both enables 0, both clear bits 0, rate field 11. The outputs irq and rti_tick are 0.
- R2: The wrap flag (bit 7) becomes 1 on the clock edge where the low eight counter stages go from 0xFF to 0x00. This is the 256th edge after reset and every 256th edge after that.
- R3: The tick flag (bit 6) becomes 1 on the clock edge where counter bit TAP_BASE+rate goes from 0 to 1. The rate field is bits 1:0, and values 0 to 3 choose bits TAP_BASE to TAP_BASE+3.
- R4: irq is a register. In each cycle it equals, from the previous cycle, (bit 7 AND bit 5) OR (bit 6 AND bit 4). Bit 5 is the wrap enable and bit 4 is the tick enable.
- R5: Writing 1 to bit 3 clears the wrap flag, and writing 1 to bit 2 clears the tick flag. Writing 0 to these bits leaves the flags unchanged, and bits 3:2 always read 0.
- R6: Values written to bits 7 and 6 never change the flags.
- R7: If a flag's set event and a write of 1 to its clear bit fall on the same edge, the flag ends up 1.
- R8: rti_tick is 1 for exactly one cycle per tick event, the cycle in which the tick flag first reads 1 from that event.
- R9: Bits 5, 4 and 1:0 take the written data only on an edge where both reg_sel and reg_wr are 1. Otherwise they hold.
- R10: After the rate field changes, tick events repeat every 2^(TAP_BASE+rate+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, takes effect with reg_sel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| irq | output | 1 | Registered interrupt request |
| rti_tick | output | 1 | One-cycle tick pulse for a watchdog |

## Verification
The bench times a clear write so that it lands on the exact edge where the counter wraps. A design that lets the clear win would lose that event and read 0 there. Writes aimed at the flag bits, and writes without the select, are followed at once by a readback, which exposes a design that stores them. The interval between ticks is measured after two rate changes, which catches a wrong tap index or a tap that ignores the field. The irq line is compared every cycle against a model delayed by one cycle, which finds a combinational or wrongly gated interrupt.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int REG_W     = 8;
  localparam int RATE_W    = 2;
  localparam int NUM_TAPS  = 1 << RATE_W;
  localparam int B_WRAP_F  = 7;
  localparam int B_TICK_F  = 6;
  localparam int B_WRAP_EN = 5;
  localparam int B_TICK_EN = 4;
  localparam int B_WRAP_CL = 3;
  localparam int B_TICK_CL = 2;
  localparam int B_RATE    = 0;
  localparam logic [RATE_W-1:0] RATE_RST = '1;
endpackage

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
  parameter int CNT_W     = 18,
  parameter int WRAP_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // the low stages are all ones, so this edge takes them back to zero
  assign wrap_evt = &cnt[WRAP_BITS-1:0];
endmodule

// File: rtl/ctmr_tap_sel.sv
module ctmr_tap_sel
  import ctmr_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int TAP_BASE = 14
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [RATE_W-1:0] rate,
  output logic              tap_evt
);
  logic [NUM_TAPS-1:0] rise_next;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int B = TAP_BASE + i;
    localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << (B + 1)) - 64'd1);
    localparam logic [CNT_W-1:0] LOW  = CNT_W'((64'd1 << B) - 64'd1);
    // bit B is 0 and every bit under it is 1: the next increment raises bit B
    assign rise_next[i] = (cnt & MASK) == LOW;
  end

  assign tap_evt = rise_next[rate];
endmodule

// File: rtl/ctmr_ctrl_reg.sv
module ctmr_ctrl_reg
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              wrap_evt,
  input  logic              tap_evt,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [RATE_W-1:0] rate,
  output logic              irq,
  output logic              rti_tick
);
  logic wrap_f, tick_f, wrap_en, tick_en;
  logic wr_hit, wrap_clr, tick_clr;

  assign wr_hit   = reg_sel & reg_wr;
  assign wrap_clr = wr_hit & reg_wdata[B_WRAP_CL];
  assign tick_clr = wr_hit & reg_wdata[B_TICK_CL];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_f   <= 1'b0;
      tick_f   <= 1'b0;
      wrap_en  <= 1'b0;
      tick_en  <= 1'b0;
      rate     <= RATE_RST;
      irq      <= 1'b0;
      rti_tick <= 1'b0;
    end else begin
      // a set event outranks a clear on the same edge
      wrap_f   <= wrap_evt | (wrap_f & ~wrap_clr);
      tick_f   <= tap_evt  | (tick_f & ~tick_clr);
      irq      <= (wrap_f & wrap_en) | (tick_f & tick_en);
      rti_tick <= tap_evt;
      if (wr_hit) begin
        wrap_en <= reg_wdata[B_WRAP_EN];
        tick_en <= reg_wdata[B_TICK_EN];
        rate    <= reg_wdata[B_RATE +: RATE_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[B_WRAP_F]  = wrap_f;
    reg_rdata[B_TICK_F]  = tick_f;
    reg_rdata[B_WRAP_EN] = wrap_en;
    reg_rdata[B_TICK_EN] = tick_en;
    reg_rdata[B_RATE +: RATE_W] = rate;
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctmr_pkg::*;
#(
  parameter int CNT_W     = 18,
  parameter int WRAP_BITS = 8,
  parameter int TAP_BASE  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             rti_tick
);
  logic [CNT_W-1:0]  cnt;
  logic              wrap_evt, tap_evt;
  logic [RATE_W-1:0] rate;

  ctmr_prescaler #(.CNT_W(CNT_W), .WRAP_BITS(WRAP_BITS)) u_pre (
    .clk(clk), .rst(rst), .cnt(cnt), .wrap_evt(wrap_evt)
  );

  ctmr_tap_sel #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE)) u_tap (
    .cnt(cnt), .rate(rate), .tap_evt(tap_evt)
  );

  ctmr_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .wrap_evt(wrap_evt), .tap_evt(tap_evt),
    .reg_rdata(reg_rdata), .rate(rate), .irq(irq), .rti_tick(rti_tick)
  );
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker
  import ctmr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq,
  input logic             rti_tick
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rti_tick |=> !rti_tick); // R8

  AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    rti_tick |-> reg_rdata[B_TICK_F]); // R3

  AST_IRQ_FROM_FLAGS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == (($past(reg_rdata[B_WRAP_F]) && $past(reg_rdata[B_WRAP_EN])) ||
                     ($past(reg_rdata[B_TICK_F]) && $past(reg_rdata[B_TICK_EN])))); // R4

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_sel && reg_wr) |=> $stable({reg_rdata[B_WRAP_EN], reg_rdata[B_TICK_EN],
                                      reg_rdata[B_RATE +: RATE_W]})); // R9

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[B_WRAP_F] && !(reg_sel && reg_wr && reg_wdata[B_WRAP_CL]))
      |=> reg_rdata[B_WRAP_F]); // R5

  AST_TICK_FLAG_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[B_TICK_F]) |-> rti_tick); // R6
endmodule

bind core_tick_timer ctmr_checker u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rti_tick(rti_tick)
);

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 10;
  localparam int TB_TAP     = 6;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, rti_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt = 0;
  bit m_wf = 0, m_tf = 0, m_we = 0, m_te = 0, m_irq = 0, m_tick = 0;
  int m_rate = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_tick_timer #(.CNT_W(TB_CNT_W), .WRAP_BITS(8), .TAP_BASE(TB_TAP)) u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rti_tick(rti_tick)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int bit_i;
    bit wrap, rise, hit, next_irq;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_wf = 0; m_tf = 0; m_we = 0; m_te = 0;
      m_rate = 3; m_irq = 0; m_tick = 0;
    end else begin
      next_irq = (m_wf && m_we) || (m_tf && m_te);
      bit_i = TB_TAP + m_rate;
      wrap = (m_cnt % 256) == 255;
      rise = (((m_cnt >> bit_i) & 1) == 0) && ((((m_cnt + 1) >> bit_i) & 1) == 1);
      hit = reg_sel && reg_wr;
      m_wf = wrap || (m_wf && !(hit && reg_wdata[3]));
      m_tf = rise || (m_tf && !(hit && reg_wdata[2]));
      if (hit) begin
        m_we = reg_wdata[5];
        m_te = reg_wdata[4];
        m_rate = reg_wdata[1:0];
      end
      m_irq = next_irq;
      m_tick = rise;
      m_cnt = (m_cnt + 1) % (1 << TB_CNT_W);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 wrap flag", reg_rdata[7], m_wf);
      chk("R3 tick flag", reg_rdata[6], m_tf);
      chk("R9 enables", reg_rdata[5:4], {m_we, m_te});
      chk("R10 rate field", reg_rdata[1:0], m_rate);
      chk("R5 clear bits read 0", reg_rdata[3:2], 0);
      chk("R4 irq", irq, m_irq);
      chk("R8 tick pulse", rti_tick, m_tick);
    end
  end

  task automatic wr(logic [7:0] d, bit s);
    @(negedge clk);
    reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!rti_tick) @(negedge clk);
  endtask

  initial begin
    int t1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", reg_rdata, 8'h03);
    chk("R1 irq at reset", irq, 0);
    chk("R1 tick at reset", rti_tick, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", reg_rdata, 8'h03);

    wr(8'h33, 1'b0);
    chk("R9 write without select", reg_rdata, 8'h03);
    wr(8'hC3, 1'b1);
    chk("R6 writes to flag bits", reg_rdata[7:6], 0);

    wr(8'h30, 1'b1);
    wait_tick();
    chk("R3 tick flag set on tick", reg_rdata[6], 1);
    @(negedge clk);
    chk("R4 irq follows enabled flag", irq, 1);
    wr(8'h30, 1'b1);
    chk("R5 zero in clear bit keeps flag", reg_rdata[6], 1);
    wr(8'h34, 1'b1);
    chk("R5 clear tick flag", reg_rdata[6], 0);

    // R7: clear write on the very edge of the wrap
    while ((m_cnt % 256) != 255) @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h38;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    chk("R7 set beats clear", reg_rdata[7], 1);
    chk("R2 wrap flag after wrap", reg_rdata[7], 1);
    wr(8'h38, 1'b1);
    chk("R5 clear wrap flag", reg_rdata[7], 0);

    // R10: rate 2 with enables off
    wr(8'h02, 1'b1);
    wait_tick();
    t1 = cyc;
    wait_tick();
    chk("R10 period at rate 2", cyc - t1, 1 << (TB_TAP + 3));
    repeat (2) @(negedge clk);
    chk("R4 flag set but disabled", {reg_rdata[6], irq}, 2);

    wr(8'h01, 1'b1);
    wait_tick();
    t1 = cyc;
    wait_tick();
    chk("R10 period at rate 1", cyc - t1, 1 << (TB_TAP + 2));
    @(negedge clk);
    chk("R8 tick lasts one cycle", rti_tick, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule